// File: doc/BRIEF.md
# NAND Prefetch and Post-Write Buffer Engine

This block moves a programmed number of bytes between a byte-wide NAND data path and a 32-bit host register port through a 64-byte FIFO. In read direction it fetches bytes from the device into the FIFO while the host drains whole words. In write direction the host posts whole words and the engine drains them to the device one byte per cycle. A transfer is started with a direction, a byte length, a FIFO threshold, a DMA-request enable and a chip-select number. A start issued while a transfer is active is refused and flagged, so software can fall back to copying the bytes itself.

A single level output reports filled bytes in read direction and free bytes in write direction. The host therefore always moves that level rounded down to a multiple of four. A remaining-byte counter, a busy flag and two sticky status bits (threshold reached, length finished) with per-bit enables and write-one-to-clear let software choose polling, interrupts or DMA pacing. An abort input returns the engine to idle.

Top module: `nand_pfpw_engine`

## Requirements
- R1: After reset, busy, remain, fifo_lvl, irq_stat, irq, dma_req, start_nack, dev_rd_en and dev_wr_en are all 0.
- R2: A start while idle (and no abort) is accepted at the clock edge: on the next cycle remain equals cfg_len, busy is 1 if cfg_len is non-zero, and the FIFO is empty; a start with cfg_len of 0 leaves busy at 0 and sets the length-finished status bit.
- R3: A start while busy sets start_nack on the following cycle and leaves remain, direction and the FIFO unchanged.
- R4: In read direction (cfg_dir=0) one byte is taken from dev_din in each cycle that dev_ready, busy and free space allow, with dev_rd_en high in that cycle; host_rd pops four bytes, the oldest in host_rd_data[7:0]; host_rd when fewer than four bytes are held is ignored.
- R5: In read direction fetching pauses while the FIFO holds 64 bytes and resumes once the host pops a word.
- R6: In write direction (cfg_dir=1) host_wr pushes host_wr_data when at least four bytes are free and busy is 1, otherwise it is ignored; bytes leave on dev_dout low byte first, one per cycle with dev_wr_en high.
- R7: fifo_lvl is the number of held bytes in read direction and 64 minus that number in write direction.
- R8: remain decreases by exactly one for every device-side byte, is 0 whenever busy is 0, and busy falls in the cycle remain reaches 0.
- R9: Status bit 0 is set in every cycle where busy is 1 and fifo_lvl is at least the latched threshold; dma_req is high under the same condition when the DMA enable was latched as 1.
- R10: Status bit 1 is set when the last programmed byte moves on the device side.
- R11: Writing 1 to an irq_clr bit clears that status bit unless its set condition holds in the same cycle, in which case it stays 1; irq is high when any status bit with its irq_en bit set is 1.
- R12: cfg_abort clears busy, remain, the FIFO and both status bits on the next cycle and takes priority over a start in the same cycle.
- R13: active_cs holds the cfg_cs value latched by the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_start | input | 1 | Start request pulse |
| cfg_abort | input | 1 | Abort: return to idle, empty FIFO, clear status |
| cfg_dir | input | 1 | 0 = read from device, 1 = write to device |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_thresh | input | 7 | FIFO threshold in bytes (0 to 64) |
| cfg_dma_en | input | 1 | Enable dma_req pacing |
| cfg_cs | input | CS_W | Chip-select number for the transfer |
| start_nack | output | 1 | Previous-cycle start was refused |
| busy | output | 1 | Transfer active |
| remain | output | LEN_W | Bytes still to move on the device side |
| active_cs | output | CS_W | Latched chip-select number |
| fifo_lvl | output | 7 | Filled bytes (read) or free bytes (write) |
| irq_en | input | 2 | Status enables: bit 0 threshold, bit 1 finished |
| irq_clr | input | 2 | Write-one-to-clear for status bits |
| irq_stat | output | 2 | Sticky status: bit 0 threshold, bit 1 finished |
| irq | output | 1 | Enabled status present |
| dma_req | output | 1 | Threshold-based DMA request |
| host_rd | input | 1 | Pop one 32-bit word (read direction) |
| host_rd_data | output | 32 | Word at FIFO head |
| host_wr | input | 1 | Push one 32-bit word (write direction) |
| host_wr_data | input | 32 | Word to push |
| dev_ready | input | 1 | Device can move a byte this cycle |
| dev_rd_en | output | 1 | Byte taken from dev_din this cycle |
| dev_din | input | 8 | Byte from device |
| dev_wr_en | output | 1 | Byte on dev_dout delivered this cycle |
| dev_dout | output | 8 | Byte to device |

## Verification
The hardest state to reach is a full FIFO with device fetch held off while a transfer is still active, because a host that reads promptly never lets the level reach 64. The stimulus starts a 100-byte read with the device always ready and withholds every host pop, so the FIFO fills and remain freezes at 36; refused starts, set-wins clearing and dma_req are then exercised from this frozen state before one pop shows the fetch resuming. The write side reaches its mirror case by posting words with the device held not ready until free space is zero, then pushing one more word that must be dropped.

// File: rtl/nand_pfpw_pkg.sv
// Shared types for the prefetch / post-write buffer engine.
package nand_pfpw_pkg;
    typedef enum logic {
        XFER_READ  = 1'b0,
        XFER_WRITE = 1'b1
    } xfer_dir_e;

    localparam int unsigned STAT_THR  = 0;
    localparam int unsigned STAT_DONE = 1;
    localparam int unsigned STAT_W    = 2;
endpackage

// File: rtl/nand_pfpw_fifo.sv
// Byte FIFO with a one-byte port and a four-byte port on each side.
// Assumes DEPTH is a power of two >= 4 and that the caller never pushes
// beyond capacity nor pops beyond content; clr empties the FIFO.
module nand_pfpw_fifo #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_byte,
    input  logic [7:0]    byte_in,
    input  logic          push_word,
    input  logic [31:0]   word_in,
    input  logic          pop_byte,
    input  logic          pop_word,
    output logic [7:0]    head_byte,
    output logic [31:0]   head_word,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] inc;
    logic [CW-1:0] dec;

    // Storage write: one byte or four consecutive bytes.
    always_ff @(posedge clk) begin
        if (push_byte) begin
            mem[wr_ptr] <= byte_in;
        end else if (push_word) begin
            for (int k = 0; k < 4; k++) begin
                mem[wr_ptr + AW'(k)] <= word_in[8*k +: 8];
            end
        end
    end

    // Amount added and removed this cycle.
    always_comb begin
        inc = push_word ? CW'(4) : (push_byte ? CW'(1) : CW'(0));
        dec = pop_word  ? CW'(4) : (pop_byte  ? CW'(1) : CW'(0));
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(inc);
            rd_ptr <= rd_ptr + AW'(dec);
            count  <= count + inc - dec;
        end
    end

    // Head views for the byte and word readers.
    always_comb begin
        head_byte = mem[rd_ptr];
        for (int k = 0; k < 4; k++) begin
            head_word[8*k +: 8] = mem[rd_ptr + AW'(k)];
        end
    end
endmodule

// File: rtl/nand_pfpw_ctrl.sv
// Transfer sequencer: accepts or refuses starts, latches the transfer
// setup, counts remaining device bytes and raises the finish pulse.
// Assumes xfer is only asserted while busy.
module nand_pfpw_ctrl
    import nand_pfpw_pkg::*;
#(
    parameter int unsigned LEN_W = 12,
    parameter int unsigned CS_W  = 3,
    parameter int unsigned CW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic             cfg_abort,
    input  logic             cfg_dir,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CW-1:0]    cfg_thresh,
    input  logic             cfg_dma_en,
    input  logic [CS_W-1:0]  cfg_cs,
    input  logic             xfer,
    output logic             accept,
    output logic             done_pulse,
    output logic             busy,
    output logic [LEN_W-1:0] remain,
    output xfer_dir_e        dir_q,
    output logic [CW-1:0]    thresh_q,
    output logic             dma_q,
    output logic [CS_W-1:0]  cs_q,
    output logic             start_nack
);
    logic last_byte;

    // Start qualification and finish detection.
    always_comb begin
        accept     = cfg_start && !busy && !cfg_abort;
        last_byte  = xfer && (remain == LEN_W'(1));
        done_pulse = (!cfg_abort && last_byte) || (accept && (cfg_len == '0));
    end

    // Busy flag and remaining-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_abort) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (accept) begin
            busy   <= (cfg_len != '0);
            remain <= cfg_len;
        end else if (xfer) begin
            remain <= remain - LEN_W'(1);
            if (last_byte) begin
                busy <= 1'b0;
            end
        end
    end

    // Transfer setup captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= XFER_READ;
            thresh_q <= '0;
            dma_q    <= 1'b0;
            cs_q     <= '0;
        end else if (accept) begin
            dir_q    <= xfer_dir_e'(cfg_dir);
            thresh_q <= cfg_thresh;
            dma_q    <= cfg_dma_en;
            cs_q     <= cfg_cs;
        end
    end

    // Refusal flag for a start issued during an active transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_nack <= 1'b0;
        end else begin
            start_nack <= cfg_start && busy && !cfg_abort;
        end
    end
endmodule

// File: rtl/nand_pfpw_irq.sv
// Sticky event status with write-one-to-clear and per-bit enables.
// A set condition in the same cycle as a clear wins; abort empties all.
module nand_pfpw_irq
    import nand_pfpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic [STAT_W-1:0] set,
    input  logic [STAT_W-1:0] clr,
    input  logic [STAT_W-1:0] en,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);
    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~clr) | set;
        end
    end

    // Interrupt line from enabled status bits.
    always_comb begin
        irq = |(stat & en);
    end
endmodule

// File: rtl/nand_pfpw_engine.sv
// Prefetch / post-write buffer engine between a 32-bit host port and a
// byte-wide NAND data path. Device strobes are combinational so a byte
// moves in the same cycle dev_ready is seen; dev_din must be valid then.
module nand_pfpw_engine
    import nand_pfpw_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LEN_W = 12,
    parameter int unsigned CS_W  = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_start,
    input  logic             cfg_abort,
    input  logic             cfg_dir,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [CW-1:0]    cfg_thresh,
    input  logic             cfg_dma_en,
    input  logic [CS_W-1:0]  cfg_cs,
    output logic             start_nack,
    output logic             busy,
    output logic [LEN_W-1:0] remain,
    output logic [CS_W-1:0]  active_cs,
    output logic [CW-1:0]    fifo_lvl,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       irq_clr,
    output logic [1:0]       irq_stat,
    output logic             irq,
    output logic             dma_req,
    input  logic             host_rd,
    output logic [31:0]      host_rd_data,
    input  logic             host_wr,
    input  logic [31:0]      host_wr_data,
    input  logic             dev_ready,
    output logic             dev_rd_en,
    input  logic [7:0]       dev_din,
    output logic             dev_wr_en,
    output logic [7:0]       dev_dout
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic          accept;
    logic          done_pulse;
    xfer_dir_e     dir_q;
    logic [CW-1:0] thresh_q;
    logic          dma_q;
    logic [CW-1:0] count;
    logic [CW-1:0] free;
    logic          push_byte;
    logic          push_word;
    logic          pop_byte;
    logic          pop_word;
    logic          thr_hit;
    logic [STAT_W-1:0] stat_set;

    // FIFO port qualification for both directions.
    always_comb begin
        free      = FULL - count;
        push_byte = busy && (dir_q == XFER_READ) && (remain != '0)
                    && (count != FULL) && dev_ready;
        pop_word  = host_rd && (dir_q == XFER_READ) && (count >= CW'(4));
        push_word = host_wr && busy && (dir_q == XFER_WRITE) && (free >= CW'(4));
        pop_byte  = busy && (dir_q == XFER_WRITE) && (remain != '0)
                    && (count != '0) && dev_ready;
    end

    // Level reporting, threshold and device strobes.
    always_comb begin
        fifo_lvl  = (dir_q == XFER_WRITE) ? free : count;
        thr_hit   = busy && (fifo_lvl >= thresh_q);
        dma_req   = thr_hit && dma_q;
        dev_rd_en = push_byte;
        dev_wr_en = pop_byte;
        stat_set  = '0;
        stat_set[STAT_THR]  = thr_hit;
        stat_set[STAT_DONE] = done_pulse;
    end

    nand_pfpw_ctrl #(
        .LEN_W(LEN_W),
        .CS_W (CS_W),
        .CW   (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_start  (cfg_start),
        .cfg_abort  (cfg_abort),
        .cfg_dir    (cfg_dir),
        .cfg_len    (cfg_len),
        .cfg_thresh (cfg_thresh),
        .cfg_dma_en (cfg_dma_en),
        .cfg_cs     (cfg_cs),
        .xfer       (push_byte || pop_byte),
        .accept     (accept),
        .done_pulse (done_pulse),
        .busy       (busy),
        .remain     (remain),
        .dir_q      (dir_q),
        .thresh_q   (thresh_q),
        .dma_q      (dma_q),
        .cs_q       (active_cs),
        .start_nack (start_nack)
    );

    nand_pfpw_fifo #(
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept || cfg_abort),
        .push_byte (push_byte),
        .byte_in   (dev_din),
        .push_word (push_word),
        .word_in   (host_wr_data),
        .pop_byte  (pop_byte),
        .pop_word  (pop_word),
        .head_byte (dev_dout),
        .head_word (host_rd_data),
        .count     (count)
    );

    nand_pfpw_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (cfg_abort),
        .set   (stat_set),
        .clr   (irq_clr),
        .en    (irq_en),
        .stat  (irq_stat),
        .irq   (irq)
    );
endmodule

// File: rtl/nand_pfpw_chk.sv
// Port-level protocol checker for nand_pfpw_engine, attached by bind.
module nand_pfpw_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LEN_W = 12,
    parameter int unsigned CW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_start,
    input logic             cfg_abort,
    input logic             busy,
    input logic [LEN_W-1:0] remain,
    input logic [CW-1:0]    fifo_lvl,
    input logic [1:0]       irq_stat,
    input logic             start_nack,
    input logic             dev_rd_en,
    input logic             dev_wr_en
);
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (remain == '0));

    assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_abort) |=>
            ((remain == $past(remain)) || (remain == $past(remain) - LEN_W'(1))));

    assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_start && !cfg_abort) |=> start_nack);

    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_abort |=> (!busy && (remain == '0) && (irq_stat == 2'b00)));

    assert_no_overfill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_en |-> (busy && !dev_wr_en && (fifo_lvl < CW'(DEPTH))));

    assert_wr_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_en |-> (busy && (remain != '0)));
endmodule

bind nand_pfpw_engine nand_pfpw_chk #(
    .DEPTH(DEPTH),
    .LEN_W(LEN_W),
    .CW   (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .cfg_abort  (cfg_abort),
    .busy       (busy),
    .remain     (remain),
    .fifo_lvl   (fifo_lvl),
    .irq_stat   (irq_stat),
    .start_nack (start_nack),
    .dev_rd_en  (dev_rd_en),
    .dev_wr_en  (dev_wr_en)
);

// File: tb/sim_nand_pfpw_engine.sv
module sim_nand_pfpw_engine;
    localparam int DEPTH = 64;
    localparam int LEN_W = 12;
    localparam int CS_W  = 3;
    localparam int CW    = 7;

    // Vector: [27] dir, [26:15] length, [14:8] threshold, [7:0] ready mask
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 12'd12,  7'd4,  8'hFF},
        {1'b0, 12'd37,  7'd16, 8'hB7},
        {1'b0, 12'd64,  7'd32, 8'hFF},
        {1'b0, 12'd130, 7'd64, 8'h7F},
        {1'b1, 12'd8,   7'd4,  8'hFF},
        {1'b1, 12'd45,  7'd24, 8'hDA},
        {1'b1, 12'd100, 7'd64, 8'hFF},
        {1'b1, 12'd3,   7'd1,  8'h55}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0, cfg_abort = 1'b0, cfg_dir = 1'b0, cfg_dma_en = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [CW-1:0] cfg_thresh = '0;
    logic [CS_W-1:0] cfg_cs = '0;
    logic start_nack, busy, irq, dma_req, dev_rd_en, dev_wr_en;
    logic [LEN_W-1:0] remain;
    logic [CS_W-1:0] active_cs;
    logic [CW-1:0] fifo_lvl;
    logic [1:0] irq_en = 2'b00, irq_clr = 2'b00, irq_stat;
    logic host_rd = 1'b0, host_wr = 1'b0, dev_ready = 1'b0;
    logic [31:0] host_rd_data, host_wr_data = '0;
    logic [7:0] dev_din = '0, dev_dout;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nand_pfpw_engine #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CS_W(CS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_abort(cfg_abort),
        .cfg_dir(cfg_dir), .cfg_len(cfg_len), .cfg_thresh(cfg_thresh),
        .cfg_dma_en(cfg_dma_en), .cfg_cs(cfg_cs), .start_nack(start_nack),
        .busy(busy), .remain(remain), .active_cs(active_cs), .fifo_lvl(fifo_lvl),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_stat(irq_stat), .irq(irq),
        .dma_req(dma_req), .host_rd(host_rd), .host_rd_data(host_rd_data),
        .host_wr(host_wr), .host_wr_data(host_wr_data), .dev_ready(dev_ready),
        .dev_rd_en(dev_rd_en), .dev_din(dev_din), .dev_wr_en(dev_wr_en),
        .dev_dout(dev_dout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((i * 37 + s * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] patw(input int s, input int w);
        return {pat(s, 4*w+3), pat(s, 4*w+2), pat(s, 4*w+1), pat(s, 4*w)};
    endfunction

    // Drive a start request (with status clear) and step to the next cycle.
    task automatic do_start(input logic dir, input int len, input int thr,
                            input logic dma, input int cs);
        cfg_start = 1'b1; cfg_dir = dir; cfg_len = LEN_W'(len);
        cfg_thresh = CW'(thr); cfg_dma_en = dma; cfg_cs = CS_W'(cs);
        irq_clr = 2'b11;
        @(negedge clk);
        cfg_start = 1'b0; irq_clr = 2'b00;
    endtask

    task automatic do_abort();
        cfg_abort = 1'b1;
        @(negedge clk);
        cfg_abort = 1'b0;
    endtask

    task automatic run_vec(input int s);
        logic dir = VEC[s][27];
        int len = int'(VEC[s][26:15]);
        int thr = int'(VEC[s][14:8]);
        logic [7:0] mask = VEC[s][7:0];
        int moved = 0, words = 0, data_bad = 0, rem_bad = 0, cyc = 0;
        int nwords = dir ? (len + 3) / 4 : len / 4;
        dev_ready = 1'b0;
        do_start(dir, len, thr, 1'b0, s % 8);
        chk($sformatf("R2 vec%0d remain after start", s), 32'(remain), 32'(len));
        chk($sformatf("R7 vec%0d level after start", s), 32'(fifo_lvl), dir ? 32'd64 : 32'd0);
        forever begin
            if (!busy && words == nwords && (dir ? 1'b1 : (moved == len))) break;
            if (cyc > 4000) begin data_bad++; break; end
            dev_ready = mask[cyc % 8];
            if (!dir) begin
                host_rd = 1'b0;
                if (fifo_lvl >= 4 && words < nwords) begin
                    if (host_rd_data !== patw(s, words)) data_bad++;
                    host_rd = 1'b1;
                    words++;
                end
                dev_din = pat(s, moved);
            end else begin
                host_wr = 1'b0;
                if (fifo_lvl >= 4 && words < nwords) begin
                    host_wr = 1'b1;
                    host_wr_data = patw(s, words);
                    words++;
                end
            end
            #1;
            if (32'(remain) != 32'(len - moved)) rem_bad++;
            if (!dir && dev_rd_en) moved++;
            if (dir && dev_wr_en) begin
                if (dev_dout !== pat(s, moved)) data_bad++;
                moved++;
            end
            @(negedge clk);
            cyc++;
        end
        host_rd = 1'b0; host_wr = 1'b0; dev_ready = 1'b0;
        chk($sformatf("%s vec%0d data mismatches", dir ? "R6" : "R4", s), 32'(data_bad), 0);
        chk($sformatf("R8 vec%0d remain tracking", s), 32'(rem_bad), 0);
        chk($sformatf("R8 vec%0d idle after finish", s), {31'd0, busy} | 32'(remain), 0);
        chk($sformatf("R10 vec%0d finished status", s), 32'(irq_stat[1]), 1);
        if (!dir)
            chk($sformatf("R4 vec%0d tail bytes held", s), 32'(fifo_lvl), 32'(len % 4));
        else begin
            chk($sformatf("R7 vec%0d free after finish", s), 32'(fifo_lvl), 32'(64 - (nwords*4 - len)));
            chk($sformatf("R9 vec%0d threshold status", s), 32'(irq_stat[0]), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {22'd0, busy, irq, dma_req, start_nack, dev_rd_en, dev_wr_en, irq_stat, 2'b00}, 0);
        chk("R1 reset remain", 32'(remain), 0);
        chk("R1 reset level", 32'(fifo_lvl), 0);

        for (int s = 0; s < 8; s++) run_vec(s);

        // R5 / R9 / R13: fill with no host pops
        dev_ready = 1'b1;
        do_start(1'b0, 100, 48, 1'b1, 2);
        repeat (70) @(negedge clk);
        chk("R5 full level", 32'(fifo_lvl), 64);
        chk("R5 remain frozen", 32'(remain), 36);
        chk("R9 dma request", 32'(dma_req), 1);
        chk("R13 latched chip select", 32'(active_cs), 2);
        // R3: refused start
        cfg_start = 1'b1; cfg_len = 12'd5; cfg_dir = 1'b1; cfg_cs = 3'd5;
        @(negedge clk);
        cfg_start = 1'b0;
        chk("R3 start_nack", 32'(start_nack), 1);
        chk("R3 remain unchanged", 32'(remain), 36);
        chk("R3 level unchanged", 32'(fifo_lvl), 64);
        chk("R13 chip select kept", 32'(active_cs), 2);
        // R11: set wins over clear, irq from enable
        irq_en = 2'b01;
        irq_clr = 2'b01;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11 set wins over clear", 32'(irq_stat[0]), 1);
        chk("R11 irq enabled bit", 32'(irq), 1);
        // R5: resume after one pop
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        repeat (10) @(negedge clk);
        chk("R5 resumed remain", 32'(remain), 32);
        chk("R5 refilled level", 32'(fifo_lvl), 64);
        // R12: abort together with start
        cfg_abort = 1'b1; cfg_start = 1'b1; cfg_len = 12'd9; cfg_dir = 1'b0;
        @(negedge clk);
        cfg_abort = 1'b0; cfg_start = 1'b0;
        chk("R12 abort busy/remain", {31'd0, busy} | 32'(remain), 0);
        chk("R12 abort level and status", {23'd0, fifo_lvl, irq_stat}, 0);
        chk("R12 abort dma", 32'(dma_req), 0);
        dev_ready = 1'b0;

        // R2 / R11: zero-length start and clear
        do_start(1'b0, 0, 4, 1'b0, 1);
        chk("R2 zero length not busy", 32'(busy), 0);
        chk("R2 zero length finished", 32'(irq_stat[1]), 1);
        irq_en = 2'b10;
        #1 chk("R11 irq from finished", 32'(irq), 1);
        irq_clr = 2'b10;
        @(negedge clk);
        irq_clr = 2'b00;
        chk("R11 clear finished", {30'd0, irq_stat}, 0);
        chk("R11 irq dropped", 32'(irq), 0);

        // R4: host_rd with fewer than four bytes ignored
        dev_ready = 1'b1;
        do_start(1'b0, 3, 4, 1'b0, 0);
        repeat (5) @(negedge clk);
        dev_ready = 1'b0;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R4 short pop ignored", 32'(fifo_lvl), 3);

        // R6: push with no free space ignored
        do_start(1'b1, 200, 8, 1'b0, 0);
        for (int w = 0; w < 17; w++) begin
            host_wr = 1'b1; host_wr_data = patw(9, w);
            @(negedge clk);
        end
        host_wr = 1'b0;
        chk("R6 full on write", 32'(fifo_lvl), 0);
        dev_ready = 1'b1;
        #1 chk("R6 first byte low first", 32'(dev_dout), 32'(pat(9, 0)));
        repeat (64) @(negedge clk);
        dev_ready = 1'b0;
        chk("R6 extra push dropped", 32'(fifo_lvl), 64);
        chk("R8 remain after drain", 32'(remain), 136);
        do_abort();

        summary();
        $finish;
    end
endmodule